// File: doc/BRIEF.md
# Backplane Select Strobe and Page-Fault Decoder

This block sits on a processor card, between the address translation logic and the backplane. It takes the translated physical address of each processor bus cycle and drives the two active-low select strobes. The memory strobe means all 20 address bits are valid. The I/O strobe means only the low 12 bits matter, so I/O space is 4 KB.

A parameterised 4 KB window in physical space is decoded as I/O. A memory card can claim an access as I/O anywhere by pulling the shared external-I/O line low. When it does, both strobes go active together. A local control register can pull the shared inhibit line low, and it can also pull the external-I/O line. While inhibit is low, the fixed window is decoded as plain memory.

Each cycle also carries the attribute bits of its page. Three separate fault flags report the following cases:
- a write to a write-protected page;
- any access to an unmapped page;
- an opcode fetch from a non-executable page.

An unmapped access produces no strobe at all. Strobes and flags are updated on the rising edge of the processor phase-2 clock and cleared on its falling edge. A bus-cut input drops the output enables of the address, data and select drivers so that another master can take the bus.

Top module: `bsel_fault_dec`

## Requirements
- R1: A valid mapped cycle outside the I/O window, with the external line high, drives `memsel_n` low and leaves `iosel_n` high. `addr_out` carries all 20 bits of `phys_addr`.
- R2: A valid mapped cycle inside the window 0xE8000–0xE8FFF, with the inhibit line high and the external line high, drives only `iosel_n` low.
- R3: When `extio_sense_n` is low during a valid mapped cycle, both `memsel_n` and `iosel_n` go low, at any address.
- R4: When `ioinh_sense_n` is low and the external line is high, a cycle inside the window drives only `memsel_n` low. I/O access is lost, and no fault flag is raised.
- R5: A write with `ctl_wr` high loads the control register. Bit 0 of `ctl_wdata` sets `ioinh_pull`, and bit 1 sets `extio_pull`. Each pull is 1 only when it drives its line low, and both pulls reset to 0. The new values appear on the clock after the write.
- R6: `fault_wprot` is 1 for a valid cycle with `rd_wn` low to a page whose `pg_wprot` is 1.
- R7: `fault_unmapped` is 1 for any valid cycle to a page with `pg_mapped` at 0. During that cycle both strobes stay high.
- R8: `fault_noexec` is 1 for a valid cycle with `sync` high to a page whose `pg_noexec` is 1.
- R9: Strobes and flags take their values one clock after `phi2` is seen rising, and hold them while `phi2` stays high. They return to inactive one clock after `phi2` falls. A cycle with `cyc_valid` low gives no strobe and no flag.
- R10: While `bus_cut` is 1, `addr_oe`, `data_oe` and `sel_oe` are 0, without waiting for a clock. Otherwise `addr_oe` and `sel_oe` are 1, and `data_oe` is 1 only for a valid write cycle.
- R11: After reset both strobes are high, all flags are 0 and both pulls are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than phase 2 |
| rst_n | input | 1 | Active-low reset |
| phi2 | input | 1 | Processor phase-2 clock, sampled on `clk` |
| cyc_valid | input | 1 | Processor performs a bus cycle |
| phys_addr | input | 20 | Translated physical address |
| rd_wn | input | 1 | 1 = read, 0 = write |
| sync | input | 1 | Opcode fetch in progress |
| pg_mapped | input | 1 | Page attribute: page is mapped |
| pg_wprot | input | 1 | Page attribute: page is write-protected |
| pg_noexec | input | 1 | Page attribute: page is not executable |
| ioinh_sense_n | input | 1 | Level of the shared inhibit line |
| extio_sense_n | input | 1 | Level of the shared external-I/O line |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 2 | Control register data |
| bus_cut | input | 1 | 1 = cut the processor off the bus |
| ioinh_pull | output | 1 | Drive inhibit line low (else released) |
| extio_pull | output | 1 | Drive external-I/O line low (else released) |
| addr_out | output | 20 | Address to backplane drivers |
| addr_oe | output | 1 | Address driver enable |
| data_oe | output | 1 | Data driver enable |
| sel_oe | output | 1 | Select strobe driver enable |
| memsel_n | output | 1 | Memory select strobe, active low |
| iosel_n | output | 1 | I/O select strobe, active low |
| fault_wprot | output | 1 | Write to protected page |
| fault_unmapped | output | 1 | Access to unmapped page |
| fault_noexec | output | 1 | Opcode fetch from non-executable page |

## Verification
The assertions assume that `phi2` and the cycle inputs are synchronous to `clk`. They also assume that `phi2` stays in each phase for at least two clocks, and that the cycle inputs are stable while `phi2` is high. The bench changes every cycle input together with `phi2` on a falling clock edge. It models each shared open-collector line as the wired-OR of the block's pull and the bench's own card pull. The inhibit level is therefore reached only through the control register. The sweep covers every page tag, both directions and fetch states, both line levels, and every attribute combination on pages inside and outside the window.

// File: rtl/bsel_pkg.sv
package bsel_pkg;
   typedef struct packed {
      logic mem;
      logic io;
      logic f_wp;
      logic f_nm;
      logic f_nx;
   } bus_dec_t;

   localparam bus_dec_t DEC_IDLE = '{mem: 1'b0, io: 1'b0, f_wp: 1'b0, f_nm: 1'b0, f_nx: 1'b0};
endpackage

// File: rtl/bsel_ctl_port.sv
module bsel_ctl_port (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr,
   input  logic [1:0] wdata,
   output logic       inh_pull,
   output logic       ext_pull
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         inh_pull <= 1'b0;
         ext_pull <= 1'b0;
      end else if (wr) begin
         inh_pull <= wdata[0];
         ext_pull <= wdata[1];
      end
   end
endmodule

// File: rtl/bsel_addr_dec.sv
module bsel_addr_dec
   import bsel_pkg::*;
#(
   parameter int unsigned TAG_W            = 8,
   parameter logic [TAG_W-1:0] WIN_TAG     = '0,
   parameter bit          UNMAP_BLOCKS_SEL = 1'b1
) (
   input  logic           valid,
   input  logic [TAG_W-1:0] tag,
   input  logic           rd_wn,
   input  logic           sync,
   input  logic           mapped,
   input  logic           wprot,
   input  logic           noexec,
   input  logic           inh,
   input  logic           ext,
   output bus_dec_t       dec
);
   logic in_win;
   logic sel_ok;

   assign in_win = (tag == WIN_TAG);

   generate
      if (UNMAP_BLOCKS_SEL) begin : g_block
         assign sel_ok = valid & mapped;
      end else begin : g_pass
         assign sel_ok = valid;
      end
   endgenerate

   always_comb begin
      dec      = DEC_IDLE;
      dec.f_nm = valid & ~mapped;
      dec.f_wp = valid & ~rd_wn & wprot;
      dec.f_nx = valid & sync & noexec;
      if (sel_ok) begin
         if (ext) begin
            dec.mem = 1'b1;
            dec.io  = 1'b1;
         end else if (in_win && !inh) begin
            dec.io  = 1'b1;
         end else begin
            dec.mem = 1'b1;
         end
      end
   end
endmodule

// File: rtl/bsel_strobe_gen.sv
module bsel_strobe_gen
   import bsel_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     phi2,
   input  bus_dec_t dec,
   output bus_dec_t dec_q
);
   logic phi2_q;
   logic rise;
   logic fall;

   assign rise = phi2 & ~phi2_q;
   assign fall = ~phi2 & phi2_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phi2_q <= 1'b0;
         dec_q  <= DEC_IDLE;
      end else begin
         phi2_q <= phi2;
         if (rise)      dec_q <= dec;
         else if (fall) dec_q <= DEC_IDLE;
      end
   end
endmodule

// File: rtl/bsel_fault_dec.sv
module bsel_fault_dec
   import bsel_pkg::*;
#(
   parameter int unsigned ADDR_W           = 20,
   parameter int unsigned IO_AW            = 12,
   parameter int unsigned IO_BASE          = 32'hE8000,
   parameter bit          UNMAP_BLOCKS_SEL = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              phi2,
   input  logic              cyc_valid,
   input  logic [ADDR_W-1:0] phys_addr,
   input  logic              rd_wn,
   input  logic              sync,
   input  logic              pg_mapped,
   input  logic              pg_wprot,
   input  logic              pg_noexec,
   input  logic              ioinh_sense_n,
   input  logic              extio_sense_n,
   input  logic              ctl_wr,
   input  logic [1:0]        ctl_wdata,
   input  logic              bus_cut,
   output logic              ioinh_pull,
   output logic              extio_pull,
   output logic [ADDR_W-1:0] addr_out,
   output logic              addr_oe,
   output logic              data_oe,
   output logic              sel_oe,
   output logic              memsel_n,
   output logic              iosel_n,
   output logic              fault_wprot,
   output logic              fault_unmapped,
   output logic              fault_noexec
);
   localparam int unsigned TAG_W = ADDR_W - IO_AW;
   localparam logic [ADDR_W-1:0] BASE_V = ADDR_W'(IO_BASE);
   localparam logic [TAG_W-1:0]  WIN_TAG = BASE_V[ADDR_W-1:IO_AW];

   generate
      if (ADDR_W > 32 || ADDR_W < 2) begin : g_bad_aw
         $error("bsel_fault_dec: ADDR_W must be 2..32");
      end
      if (IO_AW == 0 || IO_AW >= ADDR_W) begin : g_bad_io
         $error("bsel_fault_dec: IO_AW must be 1..ADDR_W-1");
      end
      if (BASE_V[IO_AW-1:0] != '0) begin : g_bad_base
         $error("bsel_fault_dec: IO_BASE must be aligned to the window");
      end
   endgenerate

   bus_dec_t dec_c;
   bus_dec_t dec_q;

   bsel_ctl_port u_ctl (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr       (ctl_wr),
      .wdata    (ctl_wdata),
      .inh_pull (ioinh_pull),
      .ext_pull (extio_pull)
   );

   bsel_addr_dec #(
      .TAG_W            (TAG_W),
      .WIN_TAG          (WIN_TAG),
      .UNMAP_BLOCKS_SEL (UNMAP_BLOCKS_SEL)
   ) u_dec (
      .valid  (cyc_valid),
      .tag    (phys_addr[ADDR_W-1:IO_AW]),
      .rd_wn  (rd_wn),
      .sync   (sync),
      .mapped (pg_mapped),
      .wprot  (pg_wprot),
      .noexec (pg_noexec),
      .inh    (~ioinh_sense_n),
      .ext    (~extio_sense_n),
      .dec    (dec_c)
   );

   bsel_strobe_gen u_stb (
      .clk   (clk),
      .rst_n (rst_n),
      .phi2  (phi2),
      .dec   (dec_c),
      .dec_q (dec_q)
   );

   assign addr_out       = phys_addr;
   assign addr_oe        = ~bus_cut;
   assign sel_oe         = ~bus_cut;
   assign data_oe        = ~bus_cut & cyc_valid & ~rd_wn;
   assign memsel_n       = ~dec_q.mem;
   assign iosel_n        = ~dec_q.io;
   assign fault_wprot    = dec_q.f_wp;
   assign fault_unmapped = dec_q.f_nm;
   assign fault_noexec   = dec_q.f_nx;
endmodule

// File: rtl/bsel_fault_dec_chk.sv
module bsel_fault_dec_chk (
   input logic clk,
   input logic rst_n,
   input logic phi2,
   input logic rd_wn,
   input logic extio_sense_n,
   input logic ctl_wr,
   input logic bus_cut,
   input logic ioinh_pull,
   input logic addr_oe,
   input logic data_oe,
   input logic sel_oe,
   input logic memsel_n,
   input logic iosel_n,
   input logic fault_wprot,
   input logic fault_unmapped,
   input logic fault_noexec
);
   // R9: one clock after phase 2 was low, everything is inactive
   a_r9_idle_in_low_phase: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!phi2) |-> (memsel_n && iosel_n && !fault_wprot && !fault_unmapped && !fault_noexec));

   // R7: an unmapped fault never coexists with an active strobe
   a_r7_unmapped_no_sel: assert property (@(posedge clk) disable iff (!rst_n)
      fault_unmapped |-> (memsel_n && iosel_n));

   // R6: a new write-protect fault follows a write cycle
   a_r6_wprot_on_write: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fault_wprot) |-> $past(!rd_wn));

   // R3: both strobes low only when the external line was low
   a_r3_both_need_ext: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(memsel_n) && $fell(iosel_n) |-> $past(!extio_sense_n));

   // R5: the inhibit pull changes only after a register write
   a_r5_pull_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(ctl_wr) |-> $stable(ioinh_pull));

   // R10: cutting the bus drops every driver enable
   a_r10_cut_releases: assert property (@(posedge clk) disable iff (!rst_n)
      bus_cut |-> (!addr_oe && !data_oe && !sel_oe));
endmodule

bind bsel_fault_dec bsel_fault_dec_chk u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .phi2           (phi2),
   .rd_wn          (rd_wn),
   .extio_sense_n  (extio_sense_n),
   .ctl_wr         (ctl_wr),
   .bus_cut        (bus_cut),
   .ioinh_pull     (ioinh_pull),
   .addr_oe        (addr_oe),
   .data_oe        (data_oe),
   .sel_oe         (sel_oe),
   .memsel_n       (memsel_n),
   .iosel_n        (iosel_n),
   .fault_wprot    (fault_wprot),
   .fault_unmapped (fault_unmapped),
   .fault_noexec   (fault_noexec)
);

// File: tb/bsel_fault_dec_tb_top.sv
module bsel_fault_dec_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        phi2 = 1'b0;
   logic        cyc_valid = 1'b0;
   logic [19:0] phys_addr = '0;
   logic        rd_wn = 1'b1;
   logic        sync = 1'b0;
   logic        pg_mapped = 1'b1;
   logic        pg_wprot = 1'b0;
   logic        pg_noexec = 1'b0;
   logic        card_ext = 1'b0;
   logic        ctl_wr = 1'b0;
   logic [1:0]  ctl_wdata = '0;
   logic        bus_cut = 1'b0;
   logic        ioinh_sense_n, extio_sense_n;
   logic        ioinh_pull, extio_pull;
   logic [19:0] addr_out;
   logic        addr_oe, data_oe, sel_oe, memsel_n, iosel_n;
   logic        fault_wprot, fault_unmapped, fault_noexec;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   // wired-OR of the open-collector lines
   assign ioinh_sense_n = ~ioinh_pull;
   assign extio_sense_n = ~(extio_pull | card_ext);

   bsel_fault_dec dut_i (
      .clk(clk), .rst_n(rst_n), .phi2(phi2), .cyc_valid(cyc_valid),
      .phys_addr(phys_addr), .rd_wn(rd_wn), .sync(sync),
      .pg_mapped(pg_mapped), .pg_wprot(pg_wprot), .pg_noexec(pg_noexec),
      .ioinh_sense_n(ioinh_sense_n), .extio_sense_n(extio_sense_n),
      .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .bus_cut(bus_cut),
      .ioinh_pull(ioinh_pull), .extio_pull(extio_pull),
      .addr_out(addr_out), .addr_oe(addr_oe), .data_oe(data_oe), .sel_oe(sel_oe),
      .memsel_n(memsel_n), .iosel_n(iosel_n), .fault_wprot(fault_wprot),
      .fault_unmapped(fault_unmapped), .fault_noexec(fault_noexec)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic ctl_write(input logic [1:0] v);
      @(negedge clk);
      ctl_wr = 1'b1; ctl_wdata = v;
      @(negedge clk);
      ctl_wr = 1'b0;
      check("R5 pulls after write", {30'd0, extio_pull, ioinh_pull}, {30'd0, v});
   endtask

   // one processor cycle; expected values from the requirements
   task automatic access(input logic [19:0] a, input logic v, input logic rw, input logic sy,
                         input logic m, input logic wp, input logic nx, input logic ext,
                         input logic inh);
      logic win, e_mem, e_io;
      logic [4:0] exp, act;
      win = (a[19:12] == 8'hE8);
      e_mem = 1'b0; e_io = 1'b0;
      if (v && m) begin
         if (ext)              begin e_mem = 1'b1; e_io = 1'b1; end
         else if (win && !inh) e_io = 1'b1;
         else                  e_mem = 1'b1;
      end
      exp = {e_mem, e_io, v & ~rw & wp, v & ~m, v & sy & nx};
      @(negedge clk);
      phys_addr = a; cyc_valid = v; rd_wn = rw; sync = sy;
      pg_mapped = m; pg_wprot = wp; pg_noexec = nx; card_ext = ext;
      phi2 = 1'b1;
      @(negedge clk);
      act = {~memsel_n, ~iosel_n, fault_wprot, fault_unmapped, fault_noexec};
      // R1 R2 R3 R4 R6 R7 R8 R9: strobes and flags in the high phase
      check("R1-R9 decode {mem,io,wp,nm,nx}", {27'd0, act}, {27'd0, exp});
      check("R10 data_oe on write", {31'd0, data_oe}, {31'd0, v & ~rw});
      check("R1 addr_out", {12'd0, addr_out}, {12'd0, a});
      @(negedge clk);
      check("R9 held while phi2 high", {27'd0, ~memsel_n, ~iosel_n, fault_wprot,
            fault_unmapped, fault_noexec}, {27'd0, exp});
      phi2 = 1'b0;
      @(negedge clk);
      check("R9 cleared after fall", {27'd0, ~memsel_n, ~iosel_n, fault_wprot,
            fault_unmapped, fault_noexec}, 32'd0);
      cyc_valid = 1'b0; card_ext = 1'b0;
   endtask

   initial begin
      #(5.0 * 190000);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11 reset state
      check("R11 strobes/flags idle", {27'd0, memsel_n, iosel_n, fault_wprot,
            fault_unmapped, fault_noexec}, 32'h18);
      check("R11 pulls released", {30'd0, extio_pull, ioinh_pull}, 32'd0);

      // R10 bus cut is immediate
      #1 bus_cut = 1'b1; cyc_valid = 1'b1; rd_wn = 1'b0;
      #1 check("R10 enables off", {29'd0, addr_oe, data_oe, sel_oe}, 32'd0);
      bus_cut = 1'b0;
      #1 check("R10 enables on", {29'd0, addr_oe, data_oe, sel_oe}, 32'h7);
      cyc_valid = 1'b0; rd_wn = 1'b1;

      // R9 invalid cycle produces nothing
      access(20'hE8010, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0);

      // page sweep under every line and direction combination (R1-R4)
      for (int inh = 0; inh < 2; inh++) begin
         ctl_write({1'b0, inh[0]});
         for (int pg = 0; pg < 256; pg++) begin
            for (int c = 0; c < 8; c++) begin
               access({pg[7:0], 12'h5A3}, 1'b1, c[0], c[1], 1'b1, 1'b0, 1'b0, c[2], inh[0]);
            end
         end
      end

      // attribute sweep on a few pages (R6 R7 R8)
      for (int inh = 0; inh < 2; inh++) begin
         ctl_write({1'b0, inh[0]});
         for (int p = 0; p < 4; p++) begin
            logic [7:0] tag;
            tag = (p == 0) ? 8'h00 : (p == 1) ? 8'hE8 : (p == 2) ? 8'hFF : 8'hE9;
            for (int at = 0; at < 8; at++) begin
               for (int c = 0; c < 8; c++) begin
                  access({tag, 12'hFFF}, 1'b1, c[0], c[1], at[0], at[1], at[2], c[2], inh[0]);
               end
            end
         end
      end

      // R3 via the block's own external pull, R4 with inhibit and no card
      ctl_write(2'b10);
      access(20'h12345, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
      ctl_write(2'b01);
      access(20'hE8000, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
      ctl_write(2'b00);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule